// File: doc/BRIEF.md
# Asynchronous Host Bus Access Front End

This block is the host-facing side of a two-channel serial controller. A host drives active-low read and write strobes together with an active-low chip enable. It also drives three qualifiers: a data/control select, a channel select and an active-low interrupt acknowledge. None of these has any phase relation to the free-running peripheral clock that clocks every flip-flop in the block. The chip enable and the strobes are combined into a single select and passed through a synchronizer. Each detected falling edge of that select becomes at most one internal register access. The internal access shows at the ports as a one-cycle read or write pulse, together with the channel and the register index that it touched.

Once an access is accepted, the block keeps a four-clock recovery interval before it takes the next one. Only accesses that actually select the device are counted. An access that lands inside the interval is dropped, and it sets a sticky violation flag. Control accesses use an indirect pointer: the first control write loads the pointer, the next control access uses it, and the pointer then returns to zero. A small per-channel register file with defined hardware-reset and channel-reset values sits behind the interface so that the access path can be observed.

Top module: `host_bus_front`

## Requirements
- R1: An access starts only when `ce_n` is low together with `rd_n` or `wr_n`. Strobe activity while `ce_n` is high gives no pulse, does not set `recov_viol`, and does not open or extend the recovery interval.
- R2: Each accepted access gives exactly one one-cycle pulse, `rd_stb` for a read or `wr_stb` for a write, never both. With the strobe falling before rising edge E1, the pulse is high from edge E3 to edge E4.
- R3: An access is honoured only if `iack_n` was sampled high on the second rising edge after the strobe falls. Otherwise it gives no pulse and changes no register or pointer.
- R4: After an accepted access, an access detected fewer than 4 clocks after it is not executed: no pulse and no register change. It sets `recov_viol`, which stays high until `rst`.
- R5: A rejected access does not restart the recovery interval. An access detected 4 or more clocks after the last accepted one is executed.
- R6: A control write (`dc_sel`=0) while the pointer is 0 loads the pointer from `wdata[3:0]`, reports index 0 and stores nothing. The next control access targets the pointed register, and the pointer then returns to 0.
- R7: A data access (`dc_sel`=1) targets register index 8 of the selected channel and leaves the pointer unchanged.
- R8: `ab_sel`=1 selects channel A and `ab_sel`=0 selects channel B. The two channels hold separate registers, except index 9 (master control), which is shared.
- R9: A read places the addressed value on `rdata` in the same cycle as `rd_stb`. `rdata` holds that value until the next accepted read.
- R10: After `rst`, in both channels: index 15 reads F8, index 11 reads 08, index 14 reads 30, index 9 reads C0, and every other index reads 00. `rdata`, `recov_viol` and `recov_busy` are 0 and the pointer is 0.
- R11: Writing index 9 with bits 7:6 = 10 resets channel A, and 01 resets channel B. A channel reset sets index 15 to F8 and index 14 bits 5:0 to 100000, keeps index 14 bits 7:6, and leaves the other registers unchanged. Bits 7:6 = 11 reloads the whole register file to the R10 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running peripheral clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| dc_sel | input | 1 | 1 = data access, 0 = control (pointer) access |
| ab_sel | input | 1 | 1 = channel A, 0 = channel B |
| iack_n | input | 1 | Interrupt acknowledge, active low; blocks accesses when low |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Data returned by the last accepted read |
| rd_stb | output | 1 | One-cycle internal read pulse |
| wr_stb | output | 1 | One-cycle internal write pulse |
| stb_chan_a | output | 1 | Channel of the current pulse (1 = A) |
| stb_index | output | 4 | Register index of the current pulse |
| recov_busy | output | 1 | Recovery interval running |
| recov_viol | output | 1 | Sticky flag: an access arrived during recovery |

## Verification
Some properties are checked on every cycle. Every pulse must follow a cycle in which chip enable was low with a strobe, and the sampled interrupt acknowledge must have been high. Pulses are single-cycle, exclusive and at least four cycles apart. The violation flag never falls outside reset. The pointer clears after an indirect access and holds across data accesses. The bench scenarios show what needs values from the register file or a specific ordering of accesses. These include the reset values, both channel resets and the full reload, the channel separation, and `rdata` holding across writes. They also show that a blocked or rejected access leaves the registers untouched, and that strobes without chip enable do not extend the recovery interval.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    localparam int DATA_W    = 8;
    localparam int IDX_W     = 4;
    localparam int NUM_REGS  = 1 << IDX_W;
    localparam int NUM_CHANS = 2;

    localparam logic [IDX_W-1:0] IDX_PTR     = 4'd0;
    localparam logic [IDX_W-1:0] IDX_DATA    = 4'd8;
    localparam logic [IDX_W-1:0] IDX_MASTER  = 4'd9;
    localparam logic [IDX_W-1:0] IDX_CLKMODE = 4'd11;
    localparam logic [IDX_W-1:0] IDX_MISC    = 4'd14;
    localparam logic [IDX_W-1:0] IDX_EXTEN   = 4'd15;

    localparam logic [DATA_W-1:0] MASTER_HW_VAL = 8'hC0;

    // Captured host request, held while the select is asserted
    typedef struct packed {
        logic              write;
        logic              data_sel;
        logic              chan_a;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Command field in bits 7:6 of the master control register
    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_RST_B  = 2'b01,
        CMD_RST_A  = 2'b10,
        CMD_RST_HW = 2'b11
    } master_cmd_e;

    function automatic logic [DATA_W-1:0] hw_reset_val(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_EXTEN:   return 8'hF8;
            IDX_CLKMODE: return 8'h08;
            IDX_MISC:    return 8'h30;
            IDX_MASTER:  return MASTER_HW_VAL;
            default:     return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] chan_reset_val(input logic [IDX_W-1:0] idx,
                                                        input logic [DATA_W-1:0] cur);
        case (idx)
            IDX_EXTEN: return 8'hF8;
            IDX_MISC:  return {cur[7:6], 6'b100000};
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/hbf_strobe_sync.sv
module hbf_strobe_sync
    import hbf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              dc_sel,
    input  logic              ab_sel,
    input  logic              iack_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              start,
    output bus_req_t          req
);

    logic                 sel_n;
    logic [SYNC_STAGES:0] chain;
    logic                 iack_q;
    logic                 fall;

    // Device is selected only while chip enable and a strobe coincide
    assign sel_n = ce_n | (rd_n & wr_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            iack_q <= 1'b1;
        end else begin
            chain  <= {chain[SYNC_STAGES-1:0], sel_n};
            iack_q <= iack_n;
        end
    end

    // Qualifiers are taken while the select is active, so they are settled
    // long before the synchronized edge uses them
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else if (!sel_n) begin
            req.write    <= !wr_n;
            req.data_sel <= dc_sel;
            req.chan_a   <= ab_sel;
            req.wdata    <= wdata;
        end
    end

    assign fall  = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
    assign start = fall & iack_q;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start |=> !start); // R2

endmodule

// File: rtl/hbf_recovery.sv
module hbf_recovery #(
    parameter int RECOV_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic viol
);

    localparam int CW = (RECOV_CLKS > 2) ? $clog2(RECOV_CLKS) : 1;

    logic [CW-1:0] cnt;

    assign busy   = (cnt != '0);
    assign accept = start & !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            viol <= 1'b0;
        end else begin
            if (accept) begin
                cnt <= CW'(RECOV_CLKS - 1);
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
            if (start && busy) begin
                viol <= 1'b1;
            end
        end
    end

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol); // R4

    AST_REJECT_KEEPS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> (cnt == $past(cnt) - 1'b1)); // R5

endmodule

// File: rtl/hbf_regfile.sv
module hbf_regfile
    import hbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op,
    input  bus_req_t          req,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              stb_chan_a,
    output logic [IDX_W-1:0]  stb_index
);

    logic [IDX_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  tgt;
    logic              ptr_load;
    logic              do_write;
    logic              master_wr;
    master_cmd_e       cmd;
    logic              hw_clear;
    logic [DATA_W-1:0] master_q;
    logic [DATA_W-1:0] chan_rd [NUM_CHANS];

    assign tgt       = req.data_sel ? IDX_DATA : ptr_q;
    assign ptr_load  = op & req.write & !req.data_sel & (ptr_q == IDX_PTR);
    assign do_write  = op & req.write & !ptr_load;
    assign master_wr = do_write & (tgt == IDX_MASTER);
    assign cmd       = master_cmd_e'(req.wdata[7:6]);
    assign hw_clear  = rst | (master_wr & (cmd == CMD_RST_HW));

    // Per-channel register banks; channel 0 is A, channel 1 is B
    for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
        logic [DATA_W-1:0] regs [NUM_REGS];
        logic              hit;
        logic              chan_rst;

        assign hit      = (req.chan_a == (c == 0));
        assign chan_rst = master_wr &
                          (((c == 0) && (cmd == CMD_RST_A)) ||
                           ((c == 1) && (cmd == CMD_RST_B)));

        always_ff @(posedge clk) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (hw_clear) begin
                    regs[r] <= hw_reset_val(IDX_W'(r));
                end else if (chan_rst) begin
                    regs[r] <= chan_reset_val(IDX_W'(r), regs[r]);
                end else if (do_write && hit && !master_wr && (tgt == IDX_W'(r))) begin
                    regs[r] <= req.wdata;
                end
            end
        end

        assign chan_rd[c] = regs[tgt];
    end

    // Master control register is shared by both channels
    always_ff @(posedge clk) begin
        if (hw_clear) begin
            master_q <= MASTER_HW_VAL;
        end else if (master_wr) begin
            master_q <= req.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= IDX_PTR;
        end else if (ptr_load) begin
            ptr_q <= req.wdata[IDX_W-1:0];
        end else if (op && !req.data_sel) begin
            ptr_q <= IDX_PTR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            rd_stb     <= 1'b0;
            wr_stb     <= 1'b0;
            stb_chan_a <= 1'b0;
            stb_index  <= '0;
        end else begin
            rd_stb <= op & !req.write;
            wr_stb <= op & req.write;
            if (op) begin
                stb_chan_a <= req.chan_a;
                stb_index  <= tgt;
            end
            if (op && !req.write) begin
                rdata <= (tgt == IDX_MASTER) ? master_q : chan_rd[req.chan_a ? 0 : 1];
            end
        end
    end

    AST_PTR_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (op && !req.data_sel && (ptr_q != IDX_PTR)) |=> (ptr_q == IDX_PTR)); // R6

    AST_DATA_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (op && req.data_sel) |=> $stable(ptr_q)); // R7

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb)); // R2

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> $stable(rdata)); // R9

endmodule

// File: rtl/host_bus_front.sv
module host_bus_front
    import hbf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RECOV_CLKS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              dc_sel,
    input  logic              ab_sel,
    input  logic              iack_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              stb_chan_a,
    output logic [IDX_W-1:0]  stb_index,
    output logic              recov_busy,
    output logic              recov_viol
);

    logic     start;
    logic     accept;
    bus_req_t req;
    logic     any_stb;

    hbf_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .dc_sel (dc_sel),
        .ab_sel (ab_sel),
        .iack_n (iack_n),
        .wdata  (wdata),
        .start  (start),
        .req    (req)
    );

    hbf_recovery #(.RECOV_CLKS(RECOV_CLKS)) u_recov (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .busy   (recov_busy),
        .viol   (recov_viol)
    );

    hbf_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .op         (accept),
        .req        (req),
        .rdata      (rdata),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .stb_chan_a (stb_chan_a),
        .stb_index  (stb_index)
    );

    assign any_stb = rd_stb | wr_stb;

    // Fixed look-back depths below match the default two-stage synchronizer
    // and a recovery interval of four clocks
    if (SYNC_STAGES == 2) begin : g_port_checks
        AST_CE_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
            any_stb |-> !$past(ce_n, 3)); // R1

        AST_IACK_GATES: assert property (@(posedge clk) disable iff (rst)
            any_stb |-> $past(iack_n, 2)); // R3
    end

    if (RECOV_CLKS == 4) begin : g_gap_check
        AST_RECOV_GAP: assert property (@(posedge clk) disable iff (rst)
            any_stb |-> !($past(any_stb, 1) || $past(any_stb, 2) || $past(any_stb, 3))); // R4
    end

endmodule

// File: tb/host_bus_front_bench.sv
module host_bus_front_bench;

    typedef struct {
        bit         wr;
        bit         chan_a;
        logic [3:0] idx;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       dc_sel = 1'b0, ab_sel = 1'b0, iack_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_stb, wr_stb, stb_chan_a, recov_busy, recov_viol;
    logic [3:0] stb_index;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    exp_t sb [$];

    always #10 clk = ~clk;

    host_bus_front u_host_bus_front (
        .clk(clk), .rst(rst), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .dc_sel(dc_sel), .ab_sel(ab_sel), .iack_n(iack_n), .wdata(wdata),
        .rdata(rdata), .rd_stb(rd_stb), .wr_stb(wr_stb), .stb_chan_a(stb_chan_a),
        .stb_index(stb_index), .recov_busy(recov_busy), .recov_viol(recov_viol)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: every pulse must match the oldest expected access
    always @(negedge clk) begin
        if (!rst && (rd_stb || wr_stb)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3/R4 unexpected pulse", {3'b0, stb_index, wr_stb}, 8'h00);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(wr_stb == e.wr && rd_stb == !e.wr, {e.tag, " kind"}, {6'b0, rd_stb, wr_stb}, {6'b0, !e.wr, e.wr});
                check(stb_chan_a == e.chan_a && stb_index == e.idx, {e.tag, " chan/index"},
                      {3'b0, stb_chan_a, stb_index}, {3'b0, e.chan_a, e.idx});
                if (!e.wr) check(rdata === e.rd, {e.tag, " rdata"}, rdata, e.rd);
            end
        end
    end

    // Driver: strobe low for two cycles, then released for gap cycles
    task automatic access(input bit wr, input bit dc, input bit ab, input logic [7:0] d,
                          input logic [3:0] eidx, input logic [7:0] erd, input bit ok,
                          input int gap, input string tag);
        exp_t e;
        ce_n = 1'b0; dc_sel = dc; ab_sel = ab; wdata = d;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        if (ok) begin
            e.wr = wr; e.chan_a = ab; e.idx = eidx; e.rd = erd; e.tag = tag;
            sb.push_back(e);
        end
        repeat (2) @(negedge clk);
        ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr_reg(input bit ab, input logic [3:0] idx, input logic [7:0] v, input string tag);
        access(1, 0, ab, {4'h0, idx}, 4'd0, 8'h00, 1, 4, {tag, " ptr"});
        access(1, 0, ab, v, idx, 8'h00, 1, 4, tag);
    endtask

    task automatic rd_reg(input bit ab, input logic [3:0] idx, input logic [7:0] exp, input string tag);
        access(1, 0, ab, {4'h0, idx}, 4'd0, 8'h00, 1, 4, {tag, " ptr"});
        access(0, 0, ab, 8'h00, idx, exp, 1, 4, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rdata == 8'h00 && !recov_viol && !recov_busy, "R10 reset outputs",
              {rdata[5:0], recov_viol, recov_busy}, 8'h00);

        // R2: pulse timing, strobe driven before E1, pulse from E3 to E4
        begin
            exp_t e;
            e.wr = 1; e.chan_a = 1; e.idx = 4'd8; e.rd = 0; e.tag = "R2 latency";
            sb.push_back(e);
            ce_n = 0; wr_n = 0; dc_sel = 1; ab_sel = 1; wdata = 8'h42;
            @(negedge clk); check(!wr_stb, "R2 no pulse after E1", {7'b0, wr_stb}, 8'h00);
            @(negedge clk); check(!wr_stb, "R2 no pulse after E2", {7'b0, wr_stb}, 8'h00);
            ce_n = 1; wr_n = 1;
            @(negedge clk); check(wr_stb && !rd_stb, "R2 pulse after E3", {6'b0, rd_stb, wr_stb}, 8'h01);
            @(negedge clk); check(!wr_stb, "R2 pulse one cycle", {7'b0, wr_stb}, 8'h00);
            repeat (4) @(negedge clk);
        end

        // R10: hardware reset values
        rd_reg(0, 4'd11, 8'h08, "R10 B clkmode");
        rd_reg(0, 4'd14, 8'h30, "R10 B misc");
        rd_reg(0, 4'd9,  8'hC0, "R10 master");
        rd_reg(1, 4'd15, 8'hF8, "R10 A exten");
        rd_reg(1, 4'd3,  8'h00, "R10 A other");

        // R8: channel separation
        wr_reg(1, 4'd5, 8'h11, "R8 wr A");
        wr_reg(0, 4'd5, 8'h22, "R8 wr B");
        rd_reg(1, 4'd5, 8'h11, "R8 rd A");
        rd_reg(0, 4'd5, 8'h22, "R8 rd B");

        // R7: data access goes to index 8, pointer untouched
        access(1, 0, 0, 8'h05, 4'd0, 8'h00, 1, 4, "R7 ptr load");
        access(1, 1, 0, 8'hAA, 4'd8, 8'h00, 1, 4, "R7 data write");
        access(0, 0, 0, 8'h00, 4'd5, 8'h22, 1, 4, "R7 ptr kept");
        access(0, 1, 0, 8'h00, 4'd8, 8'hAA, 1, 4, "R7 data read");

        // R6: pointer back at zero, control read targets index 0
        access(0, 0, 0, 8'h00, 4'd0, 8'h00, 1, 4, "R6 ptr cleared");

        // R9: rdata holds through a write
        wr_reg(1, 4'd6, 8'h77, "R9 write");
        check(rdata == 8'h00, "R9 rdata held", rdata, 8'h00);

        // R3: interrupt acknowledge low blocks the access
        iack_n = 1'b0;
        access(1, 0, 1, 8'h0F, 4'd0, 8'h00, 0, 4, "R3 blocked");
        iack_n = 1'b1;
        @(negedge clk);
        access(0, 0, 1, 8'h00, 4'd0, 8'h00, 1, 4, "R3 ptr unchanged");

        // R1: strobe without chip enable ignored, window not extended
        access(1, 1, 0, 8'h66, 4'd8, 8'h00, 1, 0, "R1 data write");
        rd_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        access(0, 1, 0, 8'h00, 4'd8, 8'h66, 1, 4, "R1 next access at 4");
        check(!recov_viol, "R1 no violation", {7'b0, recov_viol}, 8'h00);

        // R4/R5: access 3 cycles after one is rejected; one 6 after is taken
        access(1, 1, 1, 8'h5A, 4'd8, 8'h00, 1, 1, "R4 first");
        access(1, 1, 1, 8'h99, 4'd8, 8'h00, 0, 1, "R4 rejected");
        access(0, 1, 1, 8'h00, 4'd8, 8'h5A, 1, 4, "R5 accepted after reject");
        check(recov_viol, "R4 violation flag", {7'b0, recov_viol}, 8'h01);
        repeat (6) @(negedge clk);
        check(recov_viol, "R4 flag sticky", {7'b0, recov_viol}, 8'h01);

        // R11: channel reset and full reload by command
        wr_reg(1, 4'd14, 8'hFF, "R11 setup misc");
        wr_reg(1, 4'd15, 8'h00, "R11 setup exten");
        wr_reg(1, 4'd11, 8'h5A, "R11 setup clk");
        wr_reg(0, 4'd15, 8'h00, "R11 setup B exten");
        wr_reg(1, 4'd9,  8'h80, "R11 reset A cmd");
        rd_reg(1, 4'd14, 8'hE0, "R11 A misc");
        rd_reg(1, 4'd15, 8'hF8, "R11 A exten");
        rd_reg(1, 4'd11, 8'h5A, "R11 A clk kept");
        rd_reg(0, 4'd15, 8'h00, "R11 B untouched");
        wr_reg(0, 4'd9,  8'hC0, "R11 full reload cmd");
        rd_reg(1, 4'd11, 8'h08, "R11 A clk reloaded");
        rd_reg(0, 4'd9,  8'hC0, "R11 master reloaded");
        rd_reg(1, 4'd14, 8'h30, "R11 A misc reloaded");

        // R4: flag clears only on rst
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!recov_viol && rdata == 8'h00, "R4/R10 cleared by rst", {rdata[6:0], recov_viol}, 8'h00);

        repeat (8) @(negedge clk);
        check(sb.size() == 0, "R2 all expected pulses seen", 8'(sb.size()), 8'h00);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule